// File: doc/BRIEF.md
# Writeback Transaction Buffer

This block is a small, fully associative store of in-flight coherence transactions, one entry per cache line address. Each entry holds a transient protocol state and a private copy of a data block. When the cache controller evicts or invalidates a modified line, it creates an entry and copies the line's data into it. The line can then leave the cache while its writeback is still outstanding, and a forwarded exclusive request that arrives in that window is still answered with the correct data.

The controller supplies one address per cycle. Against that address the block reports combinationally whether an entry is present, the entry's state and data, and a merged state view. In that view an entry's transient state outranks the cache line's state, and a line found in neither place reads as invalid. The block also selects the data source for a forwarded request and passes state writes on to the cache line when its tag is present.

Allocation, release, state writes and data loads are commands from the controller and take effect at the next clock edge. Illegal commands are refused and reported. The controller must hold off evictions while the full flag is set. The protocol decisions are made outside this block, and so is the choice of which line to replace.

Top module: `wb_txn_buffer`

## Requirements
- R1: `hit` is high in the same cycle exactly when a valid entry holds `lookupAddr`. While `hit` is high, `entryState` and `entryData` show that entry's state and data. At most one entry ever matches a given address.
- R2: `effState` is the entry's state when `hit` is high, else `cacheState` when `cacheTagHit` is high, else the invalid code 0.
- R3: With `stateWrEn` high, the present entry's state becomes `stateWrVal` at the next edge. `cacheStateWrEn` equals `stateWrEn & cacheTagHit` in the same cycle, whether or not an entry is present.
- R4: With `allocEn` high, `freeEn` low, no entry for `lookupAddr` and the buffer not full, a new entry appears at the next edge with state `allocState` and data `cacheData`.
- R5: With `dataLoadEn` high and an entry present, that entry's data becomes `cacheData` at the next edge. With no entry present, the command has no effect.
- R6: `fwdData` is the entry's data when `hit` is high, and `cacheData` otherwise.
- R7: With `freeEn` high and an entry present, the entry is gone after the next edge.
- R8: Allocating an address that is already present, allocating while full, or freeing an absent address leaves every entry unchanged. Each of these raises `errFlag` for exactly the one cycle after the command's edge.
- R9: `full` is high exactly when all NUM_ENTRIES entries are valid. After reset the buffer is empty and `full` and `errFlag` are low.
- R10: `freeEn` takes priority over `allocEn`, `stateWrEn` and `dataLoadEn` in the same cycle. The lower-priority entry commands are then ignored and add no error of their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupAddr | input | ADDR_W | Line address for lookup and all commands |
| cacheTagHit | input | 1 | The cache holds a tag for lookupAddr |
| cacheState | input | STATE_W | The cache line's state |
| cacheData | input | DATA_W | The cache line's data block |
| allocEn | input | 1 | Create an entry for lookupAddr |
| allocState | input | STATE_W | Initial state of the new entry |
| freeEn | input | 1 | Release the entry for lookupAddr |
| stateWrEn | input | 1 | Write a state for lookupAddr |
| stateWrVal | input | STATE_W | State value to write |
| dataLoadEn | input | 1 | Copy cacheData into the present entry |
| hit | output | 1 | An entry exists for lookupAddr |
| entryState | output | STATE_W | State of the matching entry |
| entryData | output | DATA_W | Data of the matching entry |
| effState | output | STATE_W | Merged state view |
| fwdData | output | DATA_W | Data source for a forwarded request |
| cacheStateWrEn | output | 1 | Write strobe for the cache line's state |
| full | output | 1 | No free entry remains |
| errFlag | output | 1 | The previous cycle's command was refused |

## Verification
On every cycle the assertions check four things: addresses stay unique across entries, an accepted allocation or release changes the number of valid entries by exactly one in the right slot, and a refused command leaves the valid set untouched. Only the bench scenarios can show the value-level behaviour. That covers the priority of the entry state over the cache state in the merged view, the choice of data source for forwarded requests, and the fact that a data load or state write to an absent address has no effect. It also covers the same-cycle precedence of release over allocation, which the bench exercises by mixing all commands over a narrow address range that often fills the buffer.

// File: rtl/wb_txn_pkg.sv
package wb_txn_pkg;
  // Strobes from control to datapath, all aimed at one slot index
  typedef struct packed {
    logic alloc;
    logic free;
    logic stWr;
    logic dLoad;
  } txnStrobe_t;
endpackage

// File: rtl/wb_txn_ctrl.sv
module wb_txn_ctrl
  import wb_txn_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W = 8,
  parameter int IDX_W = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [ADDR_W-1:0]                 lookupAddr,
  input  logic                              allocEn,
  input  logic                              freeEn,
  input  logic                              stateWrEn,
  input  logic                              dataLoadEn,
  input  logic [NUM_ENTRIES-1:0]            validVec,
  input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] addrVec,
  output logic                              hit,
  output logic [IDX_W-1:0]                  hitIdx,
  output logic [IDX_W-1:0]                  slotIdx,
  output txnStrobe_t                        strb,
  output logic                              full,
  output logic                              errFlag
);
  logic [NUM_ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]       freeIdx;
  logic                   badCmd;
  logic                   errQ;

  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_match
    assign matchVec[gi] = validVec[gi] && (addrVec[gi] == lookupAddr);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (matchVec[i]) hitIdx = IDX_W'(i);
  end

  // lowest free slot wins
  always_comb begin
    freeIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (!validVec[i]) freeIdx = IDX_W'(i);
  end

  assign hit  = |matchVec;
  assign full = &validVec;

  always_comb begin
    strb.free  = freeEn & hit;
    strb.alloc = allocEn & ~freeEn & ~hit & ~full;
    strb.stWr  = stateWrEn & ~freeEn & hit;
    strb.dLoad = dataLoadEn & ~freeEn & hit;
  end

  assign slotIdx = strb.alloc ? freeIdx : hitIdx;
  assign badCmd  = (freeEn & ~hit) | (allocEn & ~freeEn & (hit | full));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= badCmd;
  end
  assign errFlag = errQ;

  // R1: no two entries ever share an address
  p_unique_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  // R8: a refused command leaves the valid set as it was
  p_err_no_change_r8: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> $stable(validVec));
endmodule

// File: rtl/wb_txn_data.sv
module wb_txn_data
  import wb_txn_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W = 8,
  parameter int STATE_W = 3,
  parameter int DATA_W = 32,
  parameter int IDX_W = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  txnStrobe_t                        strb,
  input  logic [IDX_W-1:0]                  slotIdx,
  input  logic [IDX_W-1:0]                  hitIdx,
  input  logic [ADDR_W-1:0]                 wrAddr,
  input  logic [STATE_W-1:0]                allocState,
  input  logic [STATE_W-1:0]                stateWrVal,
  input  logic [DATA_W-1:0]                 loadData,
  output logic [NUM_ENTRIES-1:0]            validVec,
  output logic [NUM_ENTRIES-1:0][ADDR_W-1:0] addrVec,
  output logic [STATE_W-1:0]                rdState,
  output logic [DATA_W-1:0]                 rdData
);
  logic [NUM_ENTRIES-1:0]               validQ;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0]   addrQ;
  logic [NUM_ENTRIES-1:0][STATE_W-1:0]  stateQ;
  logic [NUM_ENTRIES-1:0][DATA_W-1:0]   dataQ;

  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_slot
    logic sel;
    assign sel = (slotIdx == IDX_W'(gi));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[gi] <= 1'b0;
        addrQ[gi]  <= '0;
        stateQ[gi] <= '0;
        dataQ[gi]  <= '0;
      end else if (sel) begin
        if (strb.free) validQ[gi] <= 1'b0;
        if (strb.alloc) begin
          validQ[gi] <= 1'b1;
          addrQ[gi]  <= wrAddr;
          stateQ[gi] <= allocState;
          dataQ[gi]  <= loadData;
        end
        if (strb.stWr)  stateQ[gi] <= stateWrVal;
        if (strb.dLoad) dataQ[gi]  <= loadData;
      end
    end
  end

  assign validVec = validQ;
  assign addrVec  = addrQ;
  assign rdState  = stateQ[hitIdx];
  assign rdData   = dataQ[hitIdx];

  // R4: accepted allocation fills its slot with the requested address
  p_alloc_fills_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.alloc |=> validQ[$past(slotIdx)] && (addrQ[$past(slotIdx)] == $past(wrAddr)));

  // R4: accepted allocation adds exactly one valid entry
  p_alloc_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.alloc |=> $countones(validQ) == $past($countones(validQ)) + 1);

  // R7: release empties the slot it targets
  p_free_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.free |=> !validQ[$past(slotIdx)]);
endmodule

// File: rtl/wb_txn_buffer.sv
module wb_txn_buffer
  import wb_txn_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W = 8,
  parameter int STATE_W = 3,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  lookupAddr,
  input  logic               cacheTagHit,
  input  logic [STATE_W-1:0] cacheState,
  input  logic [DATA_W-1:0]  cacheData,
  input  logic               allocEn,
  input  logic [STATE_W-1:0] allocState,
  input  logic               freeEn,
  input  logic               stateWrEn,
  input  logic [STATE_W-1:0] stateWrVal,
  input  logic               dataLoadEn,
  output logic               hit,
  output logic [STATE_W-1:0] entryState,
  output logic [DATA_W-1:0]  entryData,
  output logic [STATE_W-1:0] effState,
  output logic [DATA_W-1:0]  fwdData,
  output logic               cacheStateWrEn,
  output logic               full,
  output logic               errFlag
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  txnStrobe_t                        strb;
  logic [IDX_W-1:0]                  hitIdx;
  logic [IDX_W-1:0]                  slotIdx;
  logic [NUM_ENTRIES-1:0]            validVec;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] addrVec;
  logic [STATE_W-1:0]                rdState;
  logic [DATA_W-1:0]                 rdData;

  wb_txn_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lookupAddr(lookupAddr),
    .allocEn(allocEn), .freeEn(freeEn), .stateWrEn(stateWrEn), .dataLoadEn(dataLoadEn),
    .validVec(validVec), .addrVec(addrVec),
    .hit(hit), .hitIdx(hitIdx), .slotIdx(slotIdx), .strb(strb),
    .full(full), .errFlag(errFlag)
  );

  wb_txn_data #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .STATE_W(STATE_W),
                .DATA_W(DATA_W), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .slotIdx(slotIdx), .hitIdx(hitIdx),
    .wrAddr(lookupAddr), .allocState(allocState), .stateWrVal(stateWrVal),
    .loadData(cacheData), .validVec(validVec), .addrVec(addrVec),
    .rdState(rdState), .rdData(rdData)
  );

  assign entryState     = rdState;
  assign entryData      = rdData;
  // transient entry state outranks the cache line; absent everywhere reads as invalid (0)
  assign effState       = hit ? rdState : (cacheTagHit ? cacheState : '0);
  assign fwdData        = hit ? rdData : cacheData;
  assign cacheStateWrEn = stateWrEn & cacheTagHit;
endmodule

// File: tb/tb_wb_txn_buffer.sv
`timescale 1ns/1ps
module tb_wb_txn_buffer;
  localparam int N = 4, AW = 8, SW = 3, DW = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic [AW-1:0] lookupAddr = '0;
  logic cacheTagHit = 1'b0, allocEn = 1'b0, freeEn = 1'b0, stateWrEn = 1'b0, dataLoadEn = 1'b0;
  logic [SW-1:0] cacheState = '0, allocState = '0, stateWrVal = '0;
  logic [DW-1:0] cacheData = '0;
  logic hit, cacheStateWrEn, full, errFlag;
  logic [SW-1:0] entryState, effState;
  logic [DW-1:0] entryData, fwdData;

  always #10 clk = ~clk;

  wb_txn_buffer #(.NUM_ENTRIES(N), .ADDR_W(AW), .STATE_W(SW), .DATA_W(DW)) dut (.*);

  int checks = 0, errors = 0;
  bit mValid [N];
  logic [AW-1:0] mAddr [N];
  logic [SW-1:0] mState [N];
  logic [DW-1:0] mData [N];
  bit expErr = 0;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int findIdx(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (mValid[i] && mAddr[i] == a) return i;
    return -1;
  endfunction

  function automatic bit mFull();
    for (int i = 0; i < N; i++) if (!mValid[i]) return 0;
    return 1;
  endfunction

  // inputs are already driven; check the outputs, then apply the edge to the model
  task automatic step();
    int idx;
    #1;
    idx = findIdx(lookupAddr);
    chk("R1 hit", DW'(hit), DW'(idx >= 0));
    if (idx >= 0) begin
      chk("R1 entryState", DW'(entryState), DW'(mState[idx]));
      chk("R1 entryData", entryData, mData[idx]);
    end
    chk("R2 effState", DW'(effState),
        DW'(idx >= 0 ? mState[idx] : (cacheTagHit ? cacheState : 3'd0)));
    chk("R6 fwdData", fwdData, idx >= 0 ? mData[idx] : cacheData);
    chk("R3 cacheStateWrEn", DW'(cacheStateWrEn), DW'(stateWrEn & cacheTagHit));
    chk("R9 full", DW'(full), DW'(mFull()));
    chk("R8 errFlag", DW'(errFlag), DW'(expErr));
    @(posedge clk);
    expErr = 0;
    if (freeEn) begin                       // R10 free outranks everything
      if (idx >= 0) mValid[idx] = 0;        // R7
      else expErr = 1;                      // R8
    end else begin
      if (allocEn) begin                    // R4
        if (idx >= 0 || mFull()) expErr = 1;
        else begin
          for (int i = 0; i < N; i++)
            if (!mValid[i]) begin
              mValid[i] = 1; mAddr[i] = lookupAddr;
              mState[i] = allocState; mData[i] = cacheData;
              break;
            end
        end
      end
      if (stateWrEn && idx >= 0) mState[idx] = stateWrVal;  // R3
      if (dataLoadEn && idx >= 0) mData[idx] = cacheData;   // R5
    end
    @(negedge clk);
  endtask

  task automatic drive(logic [AW-1:0] a, bit th, logic [SW-1:0] cs, logic [DW-1:0] cd,
                       bit al, logic [SW-1:0] ast, bit fr, bit sw, logic [SW-1:0] swv, bit dl);
    lookupAddr = a; cacheTagHit = th; cacheState = cs; cacheData = cd;
    allocEn = al; allocState = ast; freeEn = fr; stateWrEn = sw; stateWrVal = swv; dataLoadEn = dl;
    step();
  endtask

  function automatic int unsigned rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mValid[i] = 0; mAddr[i] = '0; mState[i] = '0; mData[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R9 reset hit", DW'(hit), 0);
    chk("R9 reset full", DW'(full), 0);
    chk("R9 reset errFlag", DW'(errFlag), 0);
    @(negedge clk);

    // R2 R6: empty buffer, sweep every address with and without a cache tag
    for (int a = 0; a < 256; a++)
      drive(AW'(a), a[0], SW'(a % 7), 32'hC000_0000 + a, 0, 0, 0, 0, 0, 0);

    // R4 R9: fill the buffer
    drive(8'd10, 1, 3'd2, 32'hAAAA_0010, 1, 3'd3, 0, 0, 0, 0);
    drive(8'd20, 1, 3'd2, 32'hAAAA_0020, 1, 3'd4, 0, 0, 0, 0);
    drive(8'd30, 0, 3'd0, 32'hAAAA_0030, 1, 3'd5, 0, 0, 0, 0);
    drive(8'd40, 1, 3'd2, 32'hAAAA_0040, 1, 3'd6, 0, 0, 0, 0);
    // R8: allocate while full, then a harmless cycle that shows the flag
    drive(8'd50, 1, 3'd2, 32'hBAD0_0050, 1, 3'd1, 0, 0, 0, 0);
    drive(8'd50, 1, 3'd2, 32'h0, 0, 0, 0, 0, 0, 0);
    // R1 R2: sweep with cache tag present; entry state must win where present
    for (int a = 0; a < 256; a++)
      drive(AW'(a), 1, 3'd7, 32'hD000_0000 + a, 0, 0, 0, 0, 0, 0);
    // R7: release one, R8: duplicate allocate
    drive(8'd30, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    drive(8'd20, 1, 3'd2, 32'hBAD0_0020, 1, 3'd1, 0, 0, 0, 0);
    drive(8'd20, 1, 3'd2, 32'h0, 0, 0, 0, 0, 0, 0);
    // R3: state write present and absent
    drive(8'd20, 1, 3'd2, 32'h0, 0, 0, 0, 1, 3'd1, 0);
    drive(8'd99, 1, 3'd2, 32'h0, 0, 0, 0, 1, 3'd5, 0);
    drive(8'd99, 0, 3'd2, 32'h0, 0, 0, 0, 1, 3'd5, 0);
    // R5: data load present and absent
    drive(8'd10, 1, 3'd2, 32'h5555_AAAA, 0, 0, 0, 0, 0, 1);
    drive(8'd77, 1, 3'd2, 32'h6666_BBBB, 0, 0, 0, 0, 0, 1);
    drive(8'd77, 0, 3'd0, 32'h0, 0, 0, 0, 0, 0, 0);
    drive(8'd10, 0, 3'd0, 32'h0, 0, 0, 0, 0, 0, 0);
    // R8 R7: free absent address
    drive(8'd77, 0, 3'd0, 32'h0, 0, 0, 1, 0, 0, 0);
    // R10: free and allocate together on present and absent addresses
    drive(8'd40, 0, 3'd0, 32'h0, 1, 3'd2, 1, 1, 3'd1, 1);
    drive(8'd40, 0, 3'd0, 32'h0, 1, 3'd2, 1, 0, 0, 0);
    drive(8'd40, 0, 3'd0, 32'h0, 0, 0, 0, 0, 0, 0);

    // mixed traffic over a narrow address range
    for (int k = 0; k < 4000; k++) begin
      int unsigned r = rnd();
      drive(AW'(r & 7), r[3], SW'(r[6:4]), rnd(), r[7] | r[8], SW'(r[11:9]),
            (r[12] & r[13]), r[14], SW'(r[17:15]), r[18]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule